// File: doc/BRIEF.md
# Scaled Sample Accumulator with Left Adjust

This block takes a burst of 12-bit conversion results, sums them, and turns the sum into a 16-bit value whose most significant bit is always bit 15. It also reformats every single sample as it arrives. The burst length is a power of two, chosen by a 3-bit log2 count field, so one burst holds from 1 to 128 samples. When more than 16 samples are summed, the sum is shifted right so that it fits in 16 bits. When fewer than 16 are summed and left adjust is on, the sum is shifted left so that it fills 16 bits. When fewer than 16 are summed and left adjust is off, the raw sum is reported. Exactly 16 samples need no shift.

Samples are either unsigned (single-ended) or two's complement (differential). In differential mode, the upper half of the 32-bit result repeats the sign of the 16-bit scaled value. In single-ended mode, the upper half is zero. A one-cycle start pulse clears the sum and captures the mode, left-adjust and count inputs for the whole burst. Samples enter through a valid/ready handshake. Ready is high only while a burst is open and start is low, so the source has to hold a sample and its valid until ready is seen. A sample offered while ready is low is not taken and leaves no trace. The result word is updated once per burst, with a one-cycle done pulse, and holds its value until the next burst completes.

Top module: `sample_accum_scaler`

## Requirements
- R1: While reset is asserted and after it is released, `res_word` and `fmt_word` read 0, and `res_done` and `smp_ready` read 0.
- R2: `smp_ready` is high from the cycle after a `start` pulse until the final sample of the burst is taken, and it is low in every cycle where `start` is high. A sample is taken only when `smp_valid` and `smp_ready` are both high. Samples offered while idle change no output.
- R3: A burst with count field n ends after exactly 2^n taken samples. `res_done` is high for exactly one cycle, in the cycle after the clock edge that takes the last sample, and `res_word` changes at that same edge.
- R4: For n greater than 4, the sum is shifted right arithmetically by n-4 bits and the lost bits are truncated. Example: 32 samples of 0xFFF give 0xFFF0.
- R5: For n less than 4 with left adjust on, the sum is shifted left by 4-n bits. Example: 8 samples of 0xFFF give 0xFFF0. For n equal to 4, the sum is reported unshifted.
- R6: For n less than 4 with left adjust off, the unshifted sum is reported. Example: 8 samples of 0xFFF give 0x7FF8.
- R7: In single-ended mode (`diff_mode`=0), samples are treated as unsigned and `res_word[31:16]` is zero.
- R8: In differential mode (`diff_mode`=1), samples are 12-bit two's complement and `res_word[31:16]` equals sixteen copies of `res_word[15]`. Example: one sample of 0x800 with n=0 gives 0xFFFFF800.
- R9: `fmt_word` updates in the cycle after each taken sample. With left adjust on, it holds the sample in bits 15:4 and zeros in bits 3:0. With left adjust off, it holds the sample in bits 11:0, and bits 15:12 are zero (single-ended) or copies of sample bit 11 (differential).
- R10: `res_word` keeps its value in every cycle without a `res_done` pulse.
- R11: Mode, left-adjust and count are taken from their inputs only at `start`. Changes during a burst do not affect that burst. A `start` during a burst discards the partial sum and opens a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a burst, clears the sum, captures configuration |
| diff_mode | input | 1 | 1 = differential (signed samples), 0 = single-ended |
| left_adj | input | 1 | Left adjust enable |
| samp_log2 | input | 3 | log2 of the number of samples per burst |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high while a burst is open and start is low) |
| smp_data | input | 12 | Conversion value |
| res_word | output | 32 | Scaled result with zero fill or sign extension |
| res_done | output | 1 | One-cycle pulse when a new result is loaded |
| fmt_word | output | 16 | Formatted copy of the last taken sample |

## Verification
The bound checker watches these relations on every cycle:
- the done pulse lasts exactly one cycle;
- a done pulse always follows a handshake;
- the result does not change between pulses;
- the upper result half is zero or a sign copy, depending on the mode captured at start;
- the formatted word matches the previous sample's bits;
- ready stays low during start and on a done pulse.

Only the bench's scenarios can show the rest:
- the arithmetic of the shifts for each count;
- that a burst ends after exactly 2^n samples;
- that configuration changes during a burst are ignored;
- that a restart drops the partial sum;
- that samples offered while idle are not summed.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic [0:0] {
    BURST_IDLE = 1'b0,
    BURST_OPEN = 1'b1
  } burst_state_t;

  // Accumulator width able to hold 2^(2^log_w - 1) samples of conv_w bits, signed
  function automatic int acc_width(input int conv_w, input int log_w);
    return conv_w + (1 << log_w);
  endfunction

endpackage

// File: rtl/sacc_ctrl.sv
module sacc_ctrl
  import sacc_pkg::*;
#(
  parameter int LOG_W = 3,
  localparam int CNT_W = (1 << LOG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             diff_in,
  input  logic             ladj_in,
  input  logic [LOG_W-1:0] lg_in,
  input  logic             smp_valid,
  output logic             smp_ready,
  output logic             take,
  output logic             last,
  output logic             diff_q,
  output logic             ladj_q,
  output logic [LOG_W-1:0] lg_q
);

  burst_state_t     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;

  assign target    = CNT_W'(1) << lg_q;
  assign cnt_inc   = cnt_q + CNT_W'(1);
  assign smp_ready = (state_q == BURST_OPEN) && !start;
  assign take      = smp_ready && smp_valid;
  assign last      = take && (cnt_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BURST_IDLE;
      cnt_q   <= '0;
      diff_q  <= 1'b0;
      ladj_q  <= 1'b0;
      lg_q    <= '0;
    end else if (start) begin
      state_q <= BURST_OPEN;
      cnt_q   <= '0;
      diff_q  <= diff_in;
      ladj_q  <= ladj_in;
      lg_q    <= lg_in;
    end else if (take) begin
      cnt_q <= cnt_inc;
      if (last) begin
        state_q <= BURST_IDLE;
      end
    end
  end

endmodule

// File: rtl/sacc_accum.sv
module sacc_accum #(
  parameter int CONV_W = 12,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              diff,
  input  logic [CONV_W-1:0] data,
  output logic [ACC_W-1:0]  sum_inc
);

  localparam int PAD_W = ACC_W - CONV_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] ext;
  logic             fill;

  assign fill    = diff & data[CONV_W-1];
  assign ext     = {{PAD_W{fill}}, data};
  assign sum_inc = acc_q + ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= sum_inc;
    end
  end

endmodule

// File: rtl/sacc_scale.sv
module sacc_scale #(
  parameter int ACC_W    = 20,
  parameter int LOG_W    = 3,
  parameter int NORM_LOG = 4,
  parameter int SCALED_W = 16,
  parameter int RES_W    = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [LOG_W-1:0] lg,
  input  logic             ladj,
  input  logic             diff,
  output logic [RES_W-1:0] res
);

  localparam int EXT_W = RES_W - SCALED_W;
  localparam logic [LOG_W:0] NORM_L = (LOG_W + 1)'(NORM_LOG);

  logic [LOG_W:0]           lg_x;
  logic [LOG_W:0]           rsh;
  logic [LOG_W:0]           lsh;
  logic signed [ACC_W-1:0]  acc_s;
  logic signed [ACC_W-1:0]  shifted;
  logic [SCALED_W-1:0]      scaled;

  assign lg_x  = {1'b0, lg};
  assign rsh   = lg_x - NORM_L;
  assign lsh   = NORM_L - lg_x;
  assign acc_s = $signed(acc);

  always_comb begin
    if (lg_x > NORM_L) begin
      shifted = acc_s >>> rsh;
    end else if (ladj) begin
      shifted = acc_s <<< lsh;
    end else begin
      shifted = acc_s;
    end
  end

  assign scaled = shifted[SCALED_W-1:0];

  generate
    if (EXT_W > 0) begin : g_ext
      assign res = {{EXT_W{diff & scaled[SCALED_W-1]}}, scaled};
    end else begin : g_noext
      assign res = scaled[RES_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sacc_fmt.sv
module sacc_fmt #(
  parameter int CONV_W = 12,
  parameter int FMT_W  = 16
) (
  input  logic [CONV_W-1:0] data,
  input  logic              diff,
  input  logic              ladj,
  output logic [FMT_W-1:0]  fmt
);

  localparam int PAD_W = FMT_W - CONV_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic [FMT_W-1:0] right_al;
      logic [FMT_W-1:0] left_al;
      assign right_al = {{PAD_W{diff & data[CONV_W-1]}}, data};
      assign left_al  = {data, {PAD_W{1'b0}}};
      assign fmt      = ladj ? left_al : right_al;
    end else begin : g_nopad
      assign fmt = data[CONV_W-1 -: FMT_W];
    end
  endgenerate

endmodule

// File: rtl/sample_accum_scaler.sv
module sample_accum_scaler #(
  parameter int CONV_W   = 12,
  parameter int LOG_W    = 3,
  parameter int SCALED_W = 16,
  parameter int RES_W    = 32,
  parameter int FMT_W    = 16,
  localparam int NORM_LOG = SCALED_W - CONV_W,
  localparam int ACC_W    = sacc_pkg::acc_width(CONV_W, LOG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              diff_mode,
  input  logic              left_adj,
  input  logic [LOG_W-1:0]  samp_log2,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CONV_W-1:0] smp_data,
  output logic [RES_W-1:0]  res_word,
  output logic              res_done,
  output logic [FMT_W-1:0]  fmt_word
);

  logic             take;
  logic             last;
  logic             diff_q;
  logic             ladj_q;
  logic [LOG_W-1:0] lg_q;
  logic [ACC_W-1:0] sum_inc;
  logic [RES_W-1:0] res_next;
  logic [FMT_W-1:0] fmt_next;

  sacc_ctrl #(.LOG_W(LOG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .diff_in   (diff_mode),
    .ladj_in   (left_adj),
    .lg_in     (samp_log2),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .take      (take),
    .last      (last),
    .diff_q    (diff_q),
    .ladj_q    (ladj_q),
    .lg_q      (lg_q)
  );

  sacc_accum #(.CONV_W(CONV_W), .ACC_W(ACC_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .take    (take),
    .diff    (diff_q),
    .data    (smp_data),
    .sum_inc (sum_inc)
  );

  sacc_scale #(
    .ACC_W    (ACC_W),
    .LOG_W    (LOG_W),
    .NORM_LOG (NORM_LOG),
    .SCALED_W (SCALED_W),
    .RES_W    (RES_W)
  ) u_scale (
    .acc  (sum_inc),
    .lg   (lg_q),
    .ladj (ladj_q),
    .diff (diff_q),
    .res  (res_next)
  );

  sacc_fmt #(.CONV_W(CONV_W), .FMT_W(FMT_W)) u_fmt (
    .data (smp_data),
    .diff (diff_q),
    .ladj (ladj_q),
    .fmt  (fmt_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_word <= '0;
      res_done <= 1'b0;
      fmt_word <= '0;
    end else begin
      res_done <= last;
      if (last) begin
        res_word <= res_next;
      end
      if (take) begin
        fmt_word <= fmt_next;
      end
    end
  end

endmodule

// File: rtl/sacc_checker.sv
module sacc_checker #(
  parameter int CONV_W = 12,
  parameter int LOG_W  = 3,
  parameter int RES_W  = 32,
  parameter int FMT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              diff_mode,
  input logic              left_adj,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [CONV_W-1:0] smp_data,
  input logic [RES_W-1:0]  res_word,
  input logic              res_done,
  input logic [FMT_W-1:0]  fmt_word
);

  localparam int HALF = RES_W / 2;
  localparam int PAD  = FMT_W - CONV_W;

  logic mode_seen;
  logic ladj_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen <= 1'b0;
      ladj_seen <= 1'b0;
    end else if (start) begin
      mode_seen <= diff_mode;
      ladj_seen <= left_adj;
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  assert_done_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(smp_valid && smp_ready));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> $stable(res_word));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !mode_seen) |-> (res_word[RES_W-1:HALF] == '0));

  assert_upper_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && mode_seen) |-> (res_word[RES_W-1:HALF] == {HALF{res_word[HALF-1]}}));

  assert_fmt_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && ladj_seen) |=>
      (fmt_word == {$past(smp_data), {PAD{1'b0}}}));

  assert_fmt_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !ladj_seen) |=>
      (fmt_word[CONV_W-1:0] == $past(smp_data)));

  assert_no_ready_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !smp_ready);

  assert_closed_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !start) |-> !smp_ready);

endmodule

bind sample_accum_scaler sacc_checker #(
  .CONV_W (CONV_W),
  .LOG_W  (LOG_W),
  .RES_W  (RES_W),
  .FMT_W  (FMT_W)
) u_sacc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .diff_mode (diff_mode),
  .left_adj  (left_adj),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .res_word  (res_word),
  .res_done  (res_done),
  .fmt_word  (fmt_word)
);

// File: tb/tb_sample_accum_scaler.sv
module tb_sample_accum_scaler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        diff_mode = 1'b0;
  logic        left_adj = 1'b0;
  logic [2:0]  samp_log2 = 3'd0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = 12'd0;
  logic        smp_ready;
  logic [31:0] res_word;
  logic        res_done;
  logic [15:0] fmt_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  sample_accum_scaler dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .diff_mode (diff_mode),
    .left_adj  (left_adj),
    .samp_log2 (samp_log2),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .res_word  (res_word),
    .res_done  (res_done),
    .fmt_word  (fmt_word)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference, advanced at each rising edge
  bit          m_busy = 0;
  bit          m_diff = 0;
  bit          m_ladj = 0;
  int          m_n = 0;
  int          m_cnt = 0;
  int          m_sum = 0;
  logic [31:0] m_res = 0;
  bit          m_done = 0;
  logic [15:0] m_fmt = 0;

  always @(posedge clk) begin
    int v;
    int s;
    logic [15:0] lo;
    bit hs;
    if (!rst_n) begin
      m_busy = 0; m_diff = 0; m_ladj = 0; m_n = 0; m_cnt = 0;
      m_sum = 0; m_res = 0; m_done = 0; m_fmt = 0;
    end else begin
      hs = smp_valid && m_busy && !start;
      m_done = 0;
      if (start) begin
        m_busy = 1; m_cnt = 0; m_sum = 0;
        m_diff = diff_mode; m_ladj = left_adj; m_n = int'(samp_log2);
      end else if (hs) begin
        v = m_diff ? int'($signed(smp_data)) : int'(smp_data);
        m_sum = m_sum + v;
        if (m_ladj) m_fmt = {smp_data, 4'h0};
        else m_fmt = 16'(v);
        m_cnt++;
        if (m_cnt == (1 << m_n)) begin
          s = m_sum;
          if (m_n > 4) s = s >>> (m_n - 4);
          else if (m_ladj) s = s <<< (4 - m_n);
          lo = s[15:0];
          m_res = m_diff ? {{16{lo[15]}}, lo} : {16'h0, lo};
          m_busy = 0;
          m_done = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 smp_ready", 32'(smp_ready), 32'(m_busy && !start));
      chk("R3 res_done", 32'(res_done), 32'(m_done));
      chk("R10 res_word", res_word, m_res);
      chk("R9 fmt_word", 32'(fmt_word), 32'(m_fmt));
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // All tasks enter and leave just after a falling edge
  task automatic open_burst(input bit d, input bit la, input int n);
    start = 1; diff_mode = d; left_adj = la; samp_log2 = 3'(n);
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic send(input logic [11:0] d);
    bit r;
    smp_valid = 1; smp_data = d;
    forever begin
      #1; r = smp_ready;
      @(negedge clk); #1;
      if (r) break;
    end
    smp_valid = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(negedge clk); #1; end
  endtask

  task automatic burst_const(input bit d, input bit la, input int n, input logic [11:0] v);
    open_burst(d, la, n);
    for (int i = 0; i < (1 << n); i++) send(v);
  endtask

  initial begin
    idle(3);
    chk("R1 res_word reset", res_word, 32'h0);
    chk("R1 res_done reset", 32'(res_done), 32'h0);
    chk("R1 fmt_word reset", 32'(fmt_word), 32'h0);
    chk("R1 smp_ready reset", 32'(smp_ready), 32'h0);
    rst_n = 1;
    idle(2);
    chk("R1 smp_ready after reset", 32'(smp_ready), 32'h0);

    burst_const(0, 0, 3, 12'hFFF);
    chk("R3 done after 8 samples", 32'(res_done), 32'h1);
    chk("R6 raw sum 8x0xFFF", res_word, 32'h0000_7FF8);
    chk("R9 fmt right aligned", 32'(fmt_word), 32'h0FFF);
    idle(1);
    chk("R3 done single cycle", 32'(res_done), 32'h0);

    burst_const(0, 1, 3, 12'hFFF);
    chk("R5 left shift 8x0xFFF", res_word, 32'h0000_FFF0);
    chk("R9 fmt left aligned", 32'(fmt_word), 32'hFFF0);

    burst_const(0, 0, 5, 12'hFFF);
    chk("R4 right shift 32x0xFFF", res_word, 32'h0000_FFF0);

    burst_const(0, 1, 4, 12'hFFF);
    chk("R5 no shift at 16", res_word, 32'h0000_FFF0);

    burst_const(1, 0, 0, 12'h800);
    chk("R8 diff sign extension", res_word, 32'hFFFF_F800);
    chk("R9 fmt diff sign fill", 32'(fmt_word), 32'hF800);

    burst_const(0, 0, 0, 12'h800);
    chk("R7 single-ended unsigned", res_word, 32'h0000_0800);

    // R4 truncation toward minus infinity: 128 x -1 >>> 3 = -16
    burst_const(1, 0, 7, 12'hFFF);
    chk("R4 arithmetic shift diff", res_word, 32'hFFFF_FFF0);

    // R2: samples offered while idle are not taken
    smp_valid = 1; smp_data = 12'h123;
    idle(5);
    chk("R2 idle ready low", 32'(smp_ready), 32'h0);
    chk("R10 idle result held", res_word, 32'hFFFF_FFF0);
    smp_valid = 0;
    burst_const(0, 0, 0, 12'h005);
    chk("R2 idle samples not summed", res_word, 32'h0000_0005);

    // R11: configuration changes mid-burst ignored
    open_burst(0, 1, 2);
    send(12'h100); send(12'h100);
    diff_mode = 1; left_adj = 0; samp_log2 = 3'd7;
    send(12'h100); send(12'h100);
    chk("R11 config latched", res_word, 32'h0000_1000);
    chk("R3 done after 4 samples", 32'(res_done), 32'h1);

    // R11: restart discards partial sum
    open_burst(0, 0, 1);
    send(12'hFFF);
    open_burst(0, 0, 1);
    send(12'h001); send(12'h002);
    chk("R11 restart clears", res_word, 32'h0000_0003);

    // Gaps in valid and random data
    for (int b = 0; b < 6; b++) begin
      open_burst(1'($urandom), 1'($urandom), int'($urandom_range(0, 7)));
      for (int i = 0; i < (1 << int'(samp_log2)); i++) begin
        if ($urandom_range(0, 3) == 0) idle(1);
        send(12'($urandom));
      end
      idle(2);
    end

    idle(3);
    finish_run();
  end

endmodule